// File: doc/BRIEF.md
# Register redirection table decoder

This block sits beside an instruction decoder. It stores sixteen programmable remapping entries and turns them into two lookup tables. One table covers the integer register file and the other covers the floating-point register file. Each table has one slot per architectural register number.

The decoder presents a 5-bit register number and a file select. The block answers with four things for that register:
- the physical register index that replaces the number;
- an element-width code;
- a vector flag and a packed-SIMD flag;
- a bank bit.

Instructions therefore keep their normal 5-bit register fields, and the redirection happens behind them.

Software-style control writes arrive on a single write port. Each write carries an entry number and one word holding the whole entry. A write that asks for the reserved bank is refused and reported in the same cycle. The slot count comes from a single index-width constant, so moving to 64 slots means changing one number. The lookup result is registered by default, which hides the extra table stage behind one clock of latency.

Top module: `rrt_decoder`

## Requirements
- R1: After reset every lookup, in both files, returns the identity mapping. The registered result itself resets to all zeros, which is the identity for register 0.
- R2: The entry word has the following fields.
  - bit 0: valid
  - bit 1: file type (0 = integer table, 1 = floating-point table)
  - bits 6:2: key (the slot number)
  - bits 8:7: width code
  - bits 13:9: redirected index
  - bit 14: vector flag
  - bit 15: packed flag
  - bit 16: bank

  A lookup of a mapped slot returns these value fields and raises `lk_mapped`.
- R3: An entry with type 1 changes only the floating-point table. An entry with type 0 changes only the integer table.
- R4: The key picks exactly one slot of the chosen table. All other slots are unaffected.
- R5: When several valid entries name the same slot of the same table, the entry with the highest entry number supplies that slot.
- R6: A write with bank = 1 is refused. `wr_reject` is high in the cycle of the write, and the stored entry keeps its old content. Looked-up bank is always 0.
- R7: A write with valid = 0 removes the entry. From the next cycle on, its slot falls back to any lower-numbered entry that names the same slot, or to identity if there is none.
- R8: The lookup result appears exactly one clock after the register number and file select are presented.
- R9: The width code (0 = default, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit) is returned unchanged for all four values.
- R10: A slot that no valid entry names returns the following: `lk_idx` equal to the input number, width 0, vector 0, packed 0, bank 0 and `lk_mapped` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry number to write |
| wr_data | input | 17 | Entry word (layout in R2) |
| wr_reject | output | 1 | Current write refused (reserved bank) |
| lk_fp | input | 1 | File select: 0 integer, 1 floating point |
| lk_reg | input | 5 | Architectural register number |
| lk_mapped | output | 1 | A valid entry redirects this register |
| lk_idx | output | 5 | Redirected physical register index |
| lk_width | output | 2 | Element-width code |
| lk_vec | output | 1 | Vector flag |
| lk_packed | output | 1 | Packed-SIMD flag |
| lk_bank | output | 1 | Bank bit |

## Verification
The assertions rely on three things about the inputs:
- `wr_data` and `wr_idx` are fully defined whenever `wr_en` is high.
- `lk_fp` and `lk_reg` are defined on every edge after reset.
- Reset is held across at least one clock edge.

The stimulus respects all three. It drives every input with known values from the falling clock edge and keeps the lookup inputs constant through each rising edge. It raises `wr_en` for exactly one cycle per write, and reaches the reserved bank only through deliberate refused writes.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    localparam int IDX_W     = 5;
    localparam int SLOTS     = 1 << IDX_W;
    localparam int ENT_N     = 16;
    localparam int ENT_SEL_W = $clog2(ENT_N);

    typedef enum logic [1:0] {
        EW_DEF = 2'd0,
        EW_8   = 2'd1,
        EW_16  = 2'd2,
        EW_32  = 2'd3
    } elw_e;

    // value side of an entry; field order defines the write word layout
    typedef struct packed {
        logic             bank;
        logic             pk;
        logic             vec;
        logic [IDX_W-1:0] ridx;
        elw_e             width;
    } attr_t;

    typedef struct packed {
        attr_t            attr;
        logic [IDX_W-1:0] key;
        logic             is_fp;
        logic             valid;
    } ent_t;

    typedef struct packed {
        logic  hit;
        attr_t attr;
    } slot_t;

    localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/rrt_entry_store.sv
module rrt_entry_store
    import rrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ENT_SEL_W-1:0] wr_idx,
    input  ent_t                 wr_ent,
    output logic                 wr_reject,
    output ent_t [ENT_N-1:0]     ents
);
    typedef struct packed {
        ent_t [ENT_N-1:0] ents;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wr_reject = wr_en && wr_ent.attr.bank;
        if (wr_en && !wr_ent.attr.bank) begin
            st_d.ents[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ents = st_q.ents;

    // R2: an accepted write lands in exactly the addressed entry
    for (genvar i = 0; i < ENT_N; i++) begin : g_chk
        a_r2_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == ENT_SEL_W'(i) && !wr_ent.attr.bank)
            |=> (st_q.ents[i] == $past(wr_ent)));
    end

    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ent.attr.bank) |=> $stable(st_q.ents));
endmodule

// File: rtl/rrt_expand.sv
module rrt_expand
    import rrt_pkg::*;
(
    input  ent_t  [ENT_N-1:0] ents,
    output slot_t [SLOTS-1:0] int_tab,
    output slot_t [SLOTS-1:0] fp_tab
);
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            int_tab[s].hit        = 1'b0;
            int_tab[s].attr.bank  = 1'b0;
            int_tab[s].attr.pk    = 1'b0;
            int_tab[s].attr.vec   = 1'b0;
            int_tab[s].attr.ridx  = IDX_W'(s);
            int_tab[s].attr.width = EW_DEF;
            fp_tab[s]             = int_tab[s];
        end
        // ascending order: a later entry overwrites an earlier one
        for (int e = 0; e < ENT_N; e++) begin
            if (ents[e].valid) begin
                if (ents[e].is_fp) begin
                    fp_tab[ents[e].key].hit  = 1'b1;
                    fp_tab[ents[e].key].attr = ents[e].attr;
                end else begin
                    int_tab[ents[e].key].hit  = 1'b1;
                    int_tab[ents[e].key].attr = ents[e].attr;
                end
            end
        end
    end
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
    import rrt_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t [SLOTS-1:0] int_tab,
    input  slot_t [SLOTS-1:0] fp_tab,
    input  logic              lk_fp,
    input  logic [IDX_W-1:0]  lk_reg,
    output slot_t             res
);
    slot_t sel;

    always_comb begin
        sel = lk_fp ? fp_tab[lk_reg] : int_tab[lk_reg];
    end

    if (REG_OUT) begin : g_reg
        slot_t res_d, res_q;

        always_comb begin
            res_d = sel;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end

        assign res = res_q;

        a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (res_q == $past(sel)));
    end else begin : g_comb
        assign res = sel;
    end

    a_r10_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !sel.hit |-> (sel.attr.ridx == lk_reg && sel.attr.width == EW_DEF
                      && !sel.attr.vec && !sel.attr.pk && !sel.attr.bank));

    a_r6_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res.attr.bank);
endmodule

// File: rtl/rrt_decoder.sv
module rrt_decoder
    import rrt_pkg::*;
#(
    parameter bit LOOKUP_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ENT_SEL_W-1:0] wr_idx,
    input  logic [ENT_W-1:0]     wr_data,
    output logic                 wr_reject,
    input  logic                 lk_fp,
    input  logic [IDX_W-1:0]     lk_reg,
    output logic                 lk_mapped,
    output logic [IDX_W-1:0]     lk_idx,
    output logic [1:0]           lk_width,
    output logic                 lk_vec,
    output logic                 lk_packed,
    output logic                 lk_bank
);
    ent_t  [ENT_N-1:0] ents;
    slot_t [SLOTS-1:0] int_tab;
    slot_t [SLOTS-1:0] fp_tab;
    slot_t             res;

    rrt_entry_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_ent    (ent_t'(wr_data)),
        .wr_reject (wr_reject),
        .ents      (ents)
    );

    rrt_expand u_expand (
        .ents    (ents),
        .int_tab (int_tab),
        .fp_tab  (fp_tab)
    );

    rrt_lookup #(.REG_OUT(LOOKUP_REG)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_tab (int_tab),
        .fp_tab  (fp_tab),
        .lk_fp   (lk_fp),
        .lk_reg  (lk_reg),
        .res     (res)
    );

    assign lk_mapped = res.hit;
    assign lk_idx    = res.attr.ridx;
    assign lk_width  = res.attr.width;
    assign lk_vec    = res.attr.vec;
    assign lk_packed = res.attr.pk;
    assign lk_bank   = res.attr.bank;
endmodule

// File: tb/sim_rrt_decoder.sv
`timescale 1ns/1ps
module sim_rrt_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [16:0] wr_data = '0;
    logic        wr_reject;
    logic        lk_fp = 1'b0;
    logic [4:0]  lk_reg = '0;
    logic        lk_mapped, lk_vec, lk_packed, lk_bank;
    logic [4:0]  lk_idx;
    logic [1:0]  lk_width;

    int checks = 0;
    int errors = 0;

    // bench model of the entries
    logic        m_valid [16];
    logic        m_fp    [16];
    logic [4:0]  m_key   [16];
    logic [9:0]  m_attr  [16];   // {bank,pk,vec,ridx[4:0],width[1:0]}

    always #2.5 clk = ~clk;

    rrt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_reject(wr_reject), .lk_fp(lk_fp),
        .lk_reg(lk_reg), .lk_mapped(lk_mapped), .lk_idx(lk_idx),
        .lk_width(lk_width), .lk_vec(lk_vec), .lk_packed(lk_packed),
        .lk_bank(lk_bank)
    );

    function automatic logic [10:0] got_now();
        return {lk_mapped, lk_idx, lk_width, lk_vec, lk_packed, lk_bank};
    endfunction

    function automatic logic [10:0] expect_of(input logic f, input logic [4:0] a);
        logic [10:0] r;
        r = {1'b0, a, 2'd0, 3'b000};
        for (int e = 0; e < 16; e++) begin
            if (m_valid[e] && m_fp[e] == f && m_key[e] == a)
                r = {1'b1, m_attr[e][6:2], m_attr[e][1:0],
                     m_attr[e][7], m_attr[e][8], m_attr[e][9]};
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic v, input logic f, input logic [4:0] key,
                      input logic [1:0] w, input logic [4:0] ridx,
                      input logic vec, input logic pk, input logic bank);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = idx[3:0];
        wr_data = {bank, pk, vec, ridx, w, key, f, v};
        #1;
        check("R6 wr_reject", {10'd0, wr_reject}, {10'd0, bank});
        if (!bank) begin
            m_valid[idx] = v;
            m_fp[idx]    = f;
            m_key[idx]   = key;
            m_attr[idx]  = {bank, pk, vec, ridx, w};
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 32; a++) begin
                @(negedge clk);
                lk_fp  = f[0];
                lk_reg = a[4:0];
                @(negedge clk);
                check(tag, got_now(), expect_of(f[0], a[4:0]));
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int e = 0; e < 16; e++) begin
            m_valid[e] = 1'b0; m_fp[e] = 1'b0; m_key[e] = '0; m_attr[e] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset state", got_now(), 11'd0);
        rst_n = 1'b1;
        sweep("R1 R10 identity after reset");

        // R2 R3 R4: same key in both files, different values
        wr(0, 1'b1, 1'b0, 5'd3, 2'd2, 5'd17, 1'b1, 1'b0, 1'b0);
        wr(1, 1'b1, 1'b1, 5'd3, 2'd3, 5'd9,  1'b0, 1'b1, 1'b0);
        wr(3, 1'b1, 1'b1, 5'd31, 2'd1, 5'd0, 1'b1, 1'b1, 1'b0);
        sweep("R2 R3 R4 mapped fields");

        // R5: entries 2, 5 and 9 all name integer slot 7
        wr(5, 1'b1, 1'b0, 5'd7, 2'd1, 5'd20, 1'b0, 1'b1, 1'b0);
        wr(2, 1'b1, 1'b0, 5'd7, 2'd2, 5'd21, 1'b1, 1'b0, 1'b0);
        wr(9, 1'b1, 1'b0, 5'd7, 2'd3, 5'd22, 1'b1, 1'b1, 1'b0);
        sweep("R5 highest entry wins");

        // R6: reserved bank refused, old content of entry 0 stays
        wr(0, 1'b1, 1'b0, 5'd12, 2'd1, 5'd4, 1'b0, 1'b0, 1'b1);
        wr(9, 1'b0, 1'b0, 5'd0,  2'd0, 5'd0, 1'b0, 1'b0, 1'b1);
        sweep("R6 refused write no effect");

        // R7: clearing falls back to lower entry, then to identity
        wr(9, 1'b0, 1'b0, 5'd7, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        wr(5, 1'b0, 1'b0, 5'd7, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); lk_fp = 1'b0; lk_reg = 5'd7;
        @(negedge clk);
        check("R7 fallback to entry 2", got_now(), {1'b1, 5'd21, 2'd2, 3'b100});
        wr(2, 1'b0, 1'b0, 5'd7, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 cleared slot identity", got_now(), {1'b0, 5'd7, 2'd0, 3'b000});
        sweep("R7 after clears");

        // R9: every width code on integer keys 20..23
        for (int w = 0; w < 4; w++)
            wr(10 + w, 1'b1, 1'b0, 5'(20 + w), w[1:0], 5'(30 - w), 1'b0, 1'b0, 1'b0);
        sweep("R9 width codes");

        // R8: result changes on the first edge after the input, not before
        @(negedge clk); lk_fp = 1'b0; lk_reg = 5'd22;
        @(negedge clk);
        lk_fp = 1'b1; lk_reg = 5'd3;
        #1;
        check("R8 holds until edge", got_now(), expect_of(1'b0, 5'd22));
        @(negedge clk);
        check("R8 one cycle later", got_now(), expect_of(1'b1, 5'd3));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule